// File: doc/BRIEF.md
# I2C Slave Address Matcher (7-bit and 10-bit)

This block decides whether a target on an I2C bus has been selected by the first address byte of a transfer. A bit-level receiver elsewhere assembles each byte and marks the one that arrives first after a START or repeated START. The matcher compares only that byte against a programmed slave address and raises an addressed-as-target flag when it matches. It also reports the transfer direction and flags a general-call byte on a separate output.

The slave address register holds seven upper address bits that come in on a port and one direction bit that the block stores. Software can write that stored bit. In 7-bit mode the direction bit of the received byte is ignored. In 10-bit mode the whole first byte, direction bit included, has to equal the full 8-bit register. The second byte of a 10-bit address goes to the data register and is checked by software, not by this block. Once software has accepted both bytes, it sets the stored direction bit to 1. The read-direction byte that follows the repeated START then matches in hardware.

Top module: `i2c_addr_match`

## Requirements
- R1: After reset, `slv_sel`, `gcall`, `dir_rd` and `own_rw` are all 0.
- R2: When `ten_bit` is 0, a first byte whose bits [7:1] equal `own_hi` sets `slv_sel` to 1 in the cycle after `byte_vld`, whatever bit 0 of the byte is.
- R3: When `ten_bit` is 1, a first byte matches only if all eight bits equal `{own_hi, own_rw}`, so a difference in bit 0 alone is a mismatch.
- R4: A first byte that does not match leaves `slv_sel` at 0.
- R5: A byte presented with `byte_first` at 0 never changes `slv_sel`, `gcall` or `dir_rd`.
- R6: `bus_start` or `bus_stop` clears `slv_sel`, `gcall` and `dir_rd` on the next cycle. It takes priority over a byte presented in the same cycle.
- R7: On a match, `dir_rd` takes bit 0 of the received byte (1 = read) and becomes valid in the same cycle as `slv_sel`. While `slv_sel` is 0, `dir_rd` is 0.
- R8: A first byte of 0x00 sets `gcall` to 1 and never sets `slv_sel`, even when the programmed address is all zeros.
- R9: `rw_we` loads `rw_wdata` into the stored direction bit, which shows on `own_rw` the next cycle. With `own_rw` at 1 in 10-bit mode, a first byte with bit 0 at 1 matches.
- R10: The mode is sampled in the cycle the first byte is evaluated. Changing `ten_bit` later does not alter a result already held.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| rx_byte | input | 8 | Received byte, MSB first on the wire |
| byte_vld | input | 1 | One-cycle strobe: `rx_byte` is valid |
| byte_first | input | 1 | The valid byte is the first after START/repeated START |
| bus_start | input | 1 | START or repeated START detected |
| bus_stop | input | 1 | STOP detected |
| ten_bit | input | 1 | 0 = 7-bit addressing, 1 = 10-bit addressing |
| own_hi | input | 7 | Upper seven bits of the slave address register |
| rw_we | input | 1 | Software write strobe for the stored direction bit |
| rw_wdata | input | 1 | Value written to the stored direction bit |
| own_rw | output | 1 | Stored direction bit of the address register |
| slv_sel | output | 1 | Addressed-as-target flag |
| gcall | output | 1 | General-call byte received |
| dir_rd | output | 1 | Transfer direction on a match (1 = read) |

## Verification
The bench sends the same upper bits with both values of bit 0 in each mode. A design that compared the direction bit in 7-bit mode, or ignored it in 10-bit mode, would select or reject the wrong byte. It presents bytes without the first-byte mark, which a design that gates on the strobe alone would wrongly accept. It also drives a START in the same cycle as a matching byte, which catches a design that gives the byte priority over the clear. A zero byte against an all-zero address checks that a general call is never reported as a match. The rw-bit write followed by a read-direction byte in 10-bit mode checks the repeated-START flow, which fails if the stored bit is not used in the comparison.

// File: rtl/addr_match_pkg.sv
package addr_match_pkg;
  localparam int BYTE_W = 8;
  localparam int HI_W   = BYTE_W - 1;

  typedef enum logic { MODE_7B = 1'b0, MODE_10B = 1'b1 } amode_e;

  // address agreement for one received byte
  function automatic logic f_addr_hit(
    input logic [BYTE_W-1:0] rx,
    input logic [HI_W-1:0]   hi,
    input logic              rw,
    input amode_e            mode
  );
    logic hi_eq;
    hi_eq = (rx[BYTE_W-1:1] == hi);
    if (mode == MODE_10B) return hi_eq && (rx[0] == rw);
    return hi_eq;
  endfunction

  function automatic logic f_is_gcall(input logic [BYTE_W-1:0] rx);
    return (rx == '0);
  endfunction
endpackage

// File: rtl/amatch_cmp.sv
module amatch_cmp
  import addr_match_pkg::*;
#(
  parameter int W = BYTE_W
) (
  input  logic [W-1:0] rx,
  input  logic [W-2:0] hi,
  input  logic         rw,
  input  logic         ten,
  output logic         hit,
  output logic         gc,
  output logic         dir
);
  localparam int HW = W - 1;

  logic [W-1:0] bit_eq;
  logic         fn_hit;

  genvar gi;
  generate
    for (gi = 1; gi < W; gi++) begin : g_hi
      assign bit_eq[gi] = (rx[gi] == hi[gi-1]);
    end
  endgenerate
  // direction position: compared only in 10-bit mode
  assign bit_eq[0] = ten ? (rx[0] == rw) : 1'b1;

  assign fn_hit = f_addr_hit(rx, hi, rw, amode_e'(ten));
  assign gc     = f_is_gcall(rx);
  assign hit    = (&bit_eq) && !gc;
  assign dir    = rx[0];

  always_comb begin
    if (HW > 0) AST_CMP_FN_AGREE: assert (gc || (hit == fn_hit)); // R3
  end
endmodule

// File: rtl/amatch_rwreg.sv
module amatch_rwreg (
  input  logic clk,
  input  logic rst_n,
  input  logic we,
  input  logic wdata,
  output logic rw_q
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)  rw_q <= 1'b0;
    else if (we) rw_q <= wdata;
  end

  AST_RW_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
    we |=> (rw_q == $past(wdata))); // R9
  AST_RW_KEEP: assert property (@(posedge clk) disable iff (!rst_n)
    !we |=> $stable(rw_q)); // R9
endmodule

// File: rtl/amatch_flags.sv
module amatch_flags (
  input  logic clk,
  input  logic rst_n,
  input  logic bus_clr,
  input  logic eval,
  input  logic hit,
  input  logic gc,
  input  logic dir,
  output logic sel_q,
  output logic gc_q,
  output logic dir_q
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sel_q <= 1'b0;
      gc_q  <= 1'b0;
      dir_q <= 1'b0;
    end else if (bus_clr) begin
      sel_q <= 1'b0;
      gc_q  <= 1'b0;
      dir_q <= 1'b0;
    end else if (eval) begin
      sel_q <= hit;
      gc_q  <= gc;
      dir_q <= hit & dir;
    end
  end

  AST_CLEAR_ON_BUS: assert property (@(posedge clk) disable iff (!rst_n)
    bus_clr |=> (!sel_q && !gc_q && !dir_q)); // R6
  AST_HOLD_NO_EVAL: assert property (@(posedge clk) disable iff (!rst_n)
    (!eval && !bus_clr) |=> ($stable(sel_q) && $stable(gc_q) && $stable(dir_q))); // R5
  AST_GC_NOT_SEL: assert property (@(posedge clk) disable iff (!rst_n)
    !(sel_q && gc_q)); // R8
  AST_DIR_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    !sel_q |-> !dir_q); // R7
  AST_DIR_WITH_SEL: assert property (@(posedge clk) disable iff (!rst_n)
    (eval && !bus_clr && hit) |=> (sel_q && (dir_q == $past(dir)))); // R7
endmodule

// File: rtl/i2c_addr_match.sv
module i2c_addr_match
  import addr_match_pkg::*;
#(
  parameter int W = BYTE_W
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] rx_byte,
  input  logic         byte_vld,
  input  logic         byte_first,
  input  logic         bus_start,
  input  logic         bus_stop,
  input  logic         ten_bit,
  input  logic [W-2:0] own_hi,
  input  logic         rw_we,
  input  logic         rw_wdata,
  output logic         own_rw,
  output logic         slv_sel,
  output logic         gcall,
  output logic         dir_rd
);
  // named internal events
  logic bus_clr;
  logic eval;
  logic cmp_hit;
  logic cmp_gc;
  logic cmp_dir;

  assign bus_clr = bus_start | bus_stop;
  assign eval    = byte_vld & byte_first & ~bus_clr;

  amatch_rwreg u_rw (
    .clk   (clk),
    .rst_n (rst_n),
    .we    (rw_we),
    .wdata (rw_wdata),
    .rw_q  (own_rw)
  );

  amatch_cmp #(.W(W)) u_cmp (
    .rx  (rx_byte),
    .hi  (own_hi),
    .rw  (own_rw),
    .ten (ten_bit),
    .hit (cmp_hit),
    .gc  (cmp_gc),
    .dir (cmp_dir)
  );

  amatch_flags u_flags (
    .clk     (clk),
    .rst_n   (rst_n),
    .bus_clr (bus_clr),
    .eval    (eval),
    .hit     (cmp_hit),
    .gc      (cmp_gc),
    .dir     (cmp_dir),
    .sel_q   (slv_sel),
    .gc_q    (gcall),
    .dir_q   (dir_rd)
  );

  AST_LATER_BYTE_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
    (byte_vld && !byte_first && !bus_clr) |=> $stable(slv_sel)); // R5
  AST_SEVEN_BIT_MATCH: assert property (@(posedge clk) disable iff (!rst_n)
    (eval && !ten_bit && (rx_byte[W-1:1] == own_hi) && (rx_byte != '0)) |=> slv_sel); // R2
endmodule

// File: tb/i2c_addr_match_test.sv
`timescale 1ns/1ps
module i2c_addr_match_test;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [7:0] rx_byte = '0;
  logic       byte_vld = 1'b0, byte_first = 1'b0;
  logic       bus_start = 1'b0, bus_stop = 1'b0;
  logic       ten_bit = 1'b0;
  logic [6:0] own_hi = '0;
  logic       rw_we = 1'b0, rw_wdata = 1'b0;
  logic       own_rw, slv_sel, gcall, dir_rd;

  always #2.5 clk = ~clk;

  i2c_addr_match uut (.*);

  int checks = 0;
  int fails  = 0;
  int cyc    = 0;

  // reference model state
  int m_sel = 0, m_gc = 0, m_dir = 0, m_rw = 0;

  task automatic chk(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d (cycle %0d)", tag, act, exp, cyc);
    end
  endtask

  // advance one clock: model follows the inputs, outputs compared at negedge
  task automatic step();
    int a;
    int cand;
    @(posedge clk);
    if (rst_n) begin
      if (bus_start || bus_stop) begin
        m_sel = 0; m_gc = 0; m_dir = 0;
      end else if (byte_vld && byte_first) begin
        a = int'(rx_byte);
        if (a == 0) begin
          m_gc = 1; m_sel = 0; m_dir = 0;
        end else begin
          if (ten_bit) cand = (a == int'(own_hi) * 2 + m_rw) ? 1 : 0;
          else         cand = ((a / 2) == int'(own_hi)) ? 1 : 0;
          m_gc = 0; m_sel = cand; m_dir = cand ? (a % 2) : 0;
        end
      end
      if (rw_we) m_rw = int'(rw_wdata);
    end
    @(negedge clk);
    chk("R2/R3/R4 slv_sel", int'(slv_sel), m_sel);
    chk("R8 gcall", int'(gcall), m_gc);
    chk("R7 dir_rd", int'(dir_rd), m_dir);
    chk("R9 own_rw", int'(own_rw), m_rw);
  endtask

  task automatic idle();
    byte_vld = 0; byte_first = 0; bus_start = 0; bus_stop = 0; rw_we = 0;
  endtask

  task automatic send(input logic [7:0] b, input logic first);
    rx_byte = b; byte_vld = 1; byte_first = first;
    step();
    idle();
  endtask

  task automatic start_cond();
    bus_start = 1; step(); idle();
  endtask

  task automatic stop_cond();
    bus_stop = 1; step(); idle();
  endtask

  task automatic write_rw(input logic v);
    rw_we = 1; rw_wdata = v; step(); idle();
  endtask

  initial begin
    repeat (3) @(negedge clk);
    // R1: reset state
    chk("R1 slv_sel", int'(slv_sel), 0);
    chk("R1 gcall", int'(gcall), 0);
    chk("R1 dir_rd", int'(dir_rd), 0);
    chk("R1 own_rw", int'(own_rw), 0);
    rst_n = 1;
    own_hi = 7'h2D;
    step();

    // R2: 7-bit write and read directions
    start_cond(); send({7'h2D, 1'b0}, 1);
    chk("R2 write match", int'(slv_sel), 1);
    chk("R7 write dir", int'(dir_rd), 0);
    start_cond(); send({7'h2D, 1'b1}, 1);
    chk("R2 read match", int'(slv_sel), 1);
    chk("R7 read dir", int'(dir_rd), 1);

    // R5: later bytes ignored, including a zero byte and a mismatch
    send(8'h00, 0);
    send(8'h13, 0);
    chk("R5 later bytes", int'(slv_sel), 1);
    chk("R5 no gcall", int'(gcall), 0);

    // R10: mode change after evaluation has no effect
    ten_bit = 1; step();
    chk("R10 held result", int'(slv_sel), 1);
    ten_bit = 0;

    // R6: stop clears
    stop_cond();
    chk("R6 stop clears", int'(slv_sel), 0);

    // R4: mismatch
    start_cond(); send({7'h2C, 1'b0}, 1);
    chk("R4 mismatch", int'(slv_sel), 0);

    // R6: start in same cycle as a matching first byte
    rx_byte = {7'h2D, 1'b1}; byte_vld = 1; byte_first = 1; bus_start = 1;
    step(); idle();
    chk("R6 start priority", int'(slv_sel), 0);

    // R3: 10-bit mode, stored rw is 0
    ten_bit = 1; own_hi = 7'h79;
    start_cond(); send({7'h79, 1'b1}, 1);
    chk("R3 rw mismatch", int'(slv_sel), 0);
    start_cond(); send({7'h79, 1'b0}, 1);
    chk("R3 full match", int'(slv_sel), 1);
    send(8'hA5, 0); // second address byte goes to software

    // R9: software sets rw, repeated START with read direction matches
    write_rw(1);
    chk("R9 rw stored", int'(own_rw), 1);
    start_cond(); send({7'h79, 1'b1}, 1);
    chk("R9 read after restart", int'(slv_sel), 1);
    chk("R7 10-bit dir", int'(dir_rd), 1);
    start_cond(); send({7'h79, 1'b0}, 1);
    chk("R3 write now fails", int'(slv_sel), 0);
    write_rw(0);

    // R8: general call against an all-zero address
    ten_bit = 0; own_hi = 7'h00;
    start_cond(); send(8'h00, 1);
    chk("R8 gcall set", int'(gcall), 1);
    chk("R8 not selected", int'(slv_sel), 0);
    send(8'h01, 0);
    chk("R5 gcall kept", int'(gcall), 1);
    start_cond();
    chk("R6 gcall cleared", int'(gcall), 0);
    send(8'h01, 1);
    chk("R2 zero addr read", int'(slv_sel), 1);

    // sweep several patterns in both modes
    for (int i = 0; i < 40; i++) begin
      ten_bit = i[0];
      own_hi  = 7'((i * 37) % 128);
      if (i % 5 == 0) write_rw(i[1]);
      start_cond();
      send(8'((i % 3 == 0) ? {own_hi, i[2]} : (i * 53) % 256), 1);
      send(8'((i * 11) % 256), 0);
    end
    stop_cond();

    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  always @(posedge clk) begin
    cyc++;
    if (cyc > 20000) begin
      fails++; checks++;
      $display("FAIL watchdog actual=%0d expected=%0d", cyc, 20000);
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end
endmodule